// File: doc/BRIEF.md
# I2C Receiver Acknowledge Decision

This block chooses, for every acknowledge slot of an I2C receive transfer, whether the receiver pulls SDA low to accept the byte or leaves SDA released to refuse it. It covers three receiver roles: slave receiver, master receiver with repeated transfers, and master receiver with a counted transfer. It looks at a one-shot refusal request, a stop request, a data-counter-zero flag, the two buffer-full flags, a module reset and the bit position within the byte. The framing sequencer around it shifts bits, paces SCL and marks the acknowledge slot. The sequencer uses the `sda_ack` output as the SDA value during that slot.

The decision is taken in the first cycle of the acknowledge slot and held for the rest of the slot. When the slot ends, the block records whether the byte was refused. If the refusal came from a master stop condition, it also raises a one-cycle stop strobe for the sequencer.

Top module: `i2c_rx_ack_decider`

## Requirements
- R1: In a receiver mode with no refusal cause, `sda_ack` is 0 (acknowledge) throughout the acknowledge slot. The receiver modes are `rx_mode` 2'b01 (slave receiver), 2'b10 (master, repeat) and 2'b11 (master, counted).
- R2: `sda_ack` is 1 (released) outside the acknowledge slot. It is also 1 when `rx_mode` is 2'b00 (not receiving). In that mode `last_nack` does not change.
- R3: A pulse on `nack_req_set` before the rising data-bit strobe of the last bit of a byte makes that byte's slot drive 1. A bit is the last one when `bit_rise` is high and `bit_idx` equals `bit_count` - 1.
- R4: A pulse on `nack_req_set` in the same cycle as, or after, the last-bit strobe leaves the current byte acknowledged and refuses the following byte. `nack_pending` stays 1 between the two bytes.
- R5: A refusal request is consumed by the slot that used it. The next byte is acknowledged, and `nack_pending` is 0 after that slot.
- R6: As slave receiver, the byte is refused when `rbuf_full` and `rsr_full` are both 1 at the start of the slot. Either flag alone still gives an acknowledge.
- R7: As master receiver in repeat mode, a high `stop_req` refuses the byte. `stop_force` then pulses high for exactly one cycle, in the cycle after the slot ends. `cnt_zero` has no effect in this mode.
- R8: As master receiver in counted mode with `stop_req` already held since before the previous slot ended, the byte is refused only when `cnt_zero` is 1, and it is followed by a `stop_force` pulse.
- R9: As master receiver in counted mode, a rising `stop_req` during the byte refuses that byte and is followed by a `stop_force` pulse, whatever `cnt_zero` is.
- R10: While `mod_rst` is 1, `sda_ack` is 1. A `mod_rst` pulse clears `nack_pending`, `last_nack` and `stop_force`.
- R11: `last_nack` shows the outcome of the most recent receiver slot (1 = refused) from the cycle after that slot ends, and holds until the next slot ends.
- R12: The decision is frozen at the first cycle of the slot. Buffer-flag changes later in the slot do not change `sda_ack`.
- R13: The byte length follows `bit_count` (1 to 8). With `bit_count` = 5, an early request is latched at the fifth bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mod_rst | input | 1 | Synchronous module reset, active high |
| rx_mode | input | 2 | 00 idle, 01 slave rx, 10 master rx repeat, 11 master rx counted |
| bit_count | input | 4 | Data bits per byte, 1 to 8 |
| bit_idx | input | 3 | Index of the data bit being received |
| bit_rise | input | 1 | One-cycle strobe at the SCL rising edge of a data bit |
| ack_slot | input | 1 | High during the acknowledge slot |
| nack_req_set | input | 1 | One-shot refusal request pulse |
| stop_req | input | 1 | Stop requested |
| cnt_zero | input | 1 | Data counter has reached zero |
| rbuf_full | input | 1 | Receive buffer holds unread data |
| rsr_full | input | 1 | Shift register has a complete byte |
| sda_ack | output | 1 | SDA value for the slot: 0 acknowledge, 1 released |
| last_nack | output | 1 | Outcome of the last slot, 1 = refused |
| stop_force | output | 1 | One-cycle strobe asking the sequencer for STOP |
| nack_pending | output | 1 | A refusal request is waiting or latched |

## Verification
A vector table walks every receiver role through combinations of buffer flags, stop request, counter-zero and early refusal request. This separates the causes that apply in each role from those that must be ignored there, such as `cnt_zero` in repeat mode or a single full flag for the slave. Directed byte sequences place the refusal request before and exactly at the last-bit strobe, which shows whether the request lands on the current byte or the next one. They also raise `stop_req` mid-byte versus holding it from before, which tells a new stop apart from a pending one in counted mode. Further sequences change buffer flags inside a slot and assert the module reset to confirm that decisions are frozen and that reset releases SDA.

// File: rtl/i2c_rx_ack_decider.sv
module i2c_rx_ack_decider #(
  parameter int MAX_BITS = 8,
  localparam int IDX_W = $clog2(MAX_BITS),
  localparam int CNT_W = $clog2(MAX_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mod_rst,
  input  logic [1:0]       rx_mode,
  input  logic [CNT_W-1:0] bit_count,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             bit_rise,
  input  logic             ack_slot,
  input  logic             nack_req_set,
  input  logic             stop_req,
  input  logic             cnt_zero,
  input  logic             rbuf_full,
  input  logic             rsr_full,
  output logic             sda_ack,
  output logic             last_nack,
  output logic             stop_force,
  output logic             nack_pending
);
  localparam logic [1:0] M_SLAVE = 2'b01;
  localparam logic [1:0] M_REP   = 2'b10;
  localparam logic [1:0] M_CNT   = 2'b11;

  logic req_pend, req_lat, stop_prev, stop_new, slot_q, dec_q, stop_q;
  logic rx, last_bit, slot_start, slot_end, stop_cause, nack_cond, live_nack;

  assign rx         = rx_mode != 2'b00;
  assign last_bit   = bit_rise && (CNT_W'(bit_idx) == bit_count - CNT_W'(1));
  assign slot_start = ack_slot && !slot_q;
  assign slot_end   = slot_q && !ack_slot;

  always_comb begin
    case (rx_mode)
      M_REP:   stop_cause = stop_req;
      M_CNT:   stop_cause = stop_req && (cnt_zero || stop_new);
      default: stop_cause = 1'b0;
    endcase
  end

  assign nack_cond    = req_lat || (rx_mode == M_SLAVE && rbuf_full && rsr_full) || stop_cause;
  assign live_nack    = slot_q ? dec_q : nack_cond;
  assign sda_ack      = !(rx && ack_slot && !mod_rst && !live_nack);
  assign nack_pending = req_pend || req_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_pend   <= 1'b0;
      req_lat    <= 1'b0;
      stop_prev  <= 1'b0;
      stop_new   <= 1'b0;
      slot_q     <= 1'b0;
      dec_q      <= 1'b0;
      stop_q     <= 1'b0;
      last_nack  <= 1'b0;
      stop_force <= 1'b0;
    end else begin
      stop_prev <= stop_req;
      slot_q    <= ack_slot && !mod_rst;
      if (mod_rst) begin
        req_pend   <= 1'b0;
        req_lat    <= 1'b0;
        stop_new   <= 1'b0;
        dec_q      <= 1'b0;
        stop_q     <= 1'b0;
        last_nack  <= 1'b0;
        stop_force <= 1'b0;
      end else begin
        stop_force <= slot_end && dec_q && stop_q;
        if (last_bit) begin
          req_lat  <= req_pend;
          req_pend <= nack_req_set;
        end else begin
          req_pend <= req_pend || nack_req_set;
          if (slot_end) req_lat <= 1'b0;
        end
        if (stop_req && !stop_prev) stop_new <= 1'b1;
        else if (slot_end)          stop_new <= 1'b0;
        if (slot_start) begin
          dec_q  <= nack_cond;
          stop_q <= stop_cause;
        end
        if (slot_end && rx) last_nack <= dec_q;
      end
    end
  end

  a_r12_frozen_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_slot && slot_q && !mod_rst && $past(!mod_rst) && $stable(rx_mode)) |-> $stable(sda_ack));

  a_r7_stop_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_force |=> !stop_force);

  a_r7_stop_after_refusal: assert property (@(posedge clk) disable iff (!rst_n)
    stop_force |-> last_nack);

  a_r10_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    mod_rst |=> (!nack_pending && !stop_force && !last_nack));

  a_r5_request_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && !mod_rst && !last_bit) |=> !req_lat);

  a_r11_outcome_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_end && !mod_rst) |=> $stable(last_nack));
endmodule

// File: tb/i2c_rx_ack_decider_bench.sv
`timescale 1ns/1ps
module i2c_rx_ack_decider_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mod_rst = 1'b0;
  logic [1:0] rx_mode = 2'b00;
  logic [3:0] bit_count = 4'd8;
  logic [2:0] bit_idx = 3'd0;
  logic       bit_rise = 1'b0, ack_slot = 1'b0, nack_req_set = 1'b0;
  logic       stop_req = 1'b0, cnt_zero = 1'b0, rbuf_full = 1'b0, rsr_full = 1'b0;
  logic       sda_ack, last_nack, stop_force, nack_pending;

  int checks = 0;
  int errors = 0;
  logic got_sda, got_sda2, got_stop, got_stop2, got_last;

  always #2.5 clk = ~clk;

  i2c_rx_ack_decider u_i2c_rx_ack_decider (
    .clk(clk), .rst_n(rst_n), .mod_rst(mod_rst), .rx_mode(rx_mode),
    .bit_count(bit_count), .bit_idx(bit_idx), .bit_rise(bit_rise),
    .ack_slot(ack_slot), .nack_req_set(nack_req_set), .stop_req(stop_req),
    .cnt_zero(cnt_zero), .rbuf_full(rbuf_full), .rsr_full(rsr_full),
    .sda_ack(sda_ack), .last_nack(last_nack), .stop_force(stop_force),
    .nack_pending(nack_pending));

  // [12:11] mode [10] rbuf [9] rsr [8] stop [7] cnt0 [6] early req [5:2] bits [1] exp sda [0] exp stop
  localparam int NV = 12;
  localparam logic [12:0] VEC [NV] = '{
    {2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8, 1'b0, 1'b0},  // R1
    {2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8, 1'b0, 1'b0},  // R6
    {2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd8, 1'b0, 1'b0},  // R6
    {2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd8, 1'b1, 1'b0},  // R6
    {2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd8, 1'b1, 1'b0},  // R3
    {2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd8, 1'b1, 1'b1},  // R7
    {2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd8, 1'b0, 1'b0},  // R7
    {2'b11, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd8, 1'b1, 1'b1},  // R8
    {2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd8, 1'b0, 1'b0},  // R8
    {2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd8, 1'b0, 1'b0},  // R1
    {2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd8, 1'b1, 1'b0},  // R2
    {2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd5, 1'b1, 1'b0}   // R13
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic pulse_mod_rst();
    @(negedge clk); mod_rst = 1'b1;
    @(negedge clk); mod_rst = 1'b0;
  endtask

  task automatic do_byte(input int nb, input bit early, input bit late, input int stop_at, input bit mid_ovr);
    bit_count = 4'(nb);
    if (early) begin
      @(negedge clk); nack_req_set = 1'b1;
      @(negedge clk); nack_req_set = 1'b0;
    end
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      bit_idx = 3'(i);
      bit_rise = 1'b1;
      if (late && i == nb - 1) nack_req_set = 1'b1;
      if (i == stop_at) stop_req = 1'b1;
      @(negedge clk);
      bit_rise = 1'b0;
      nack_req_set = 1'b0;
    end
    @(negedge clk); ack_slot = 1'b1;
    #1 got_sda = sda_ack;
    @(negedge clk);
    if (mid_ovr) begin rbuf_full = 1'b1; rsr_full = 1'b1; end
    @(negedge clk); #1 got_sda2 = sda_ack;
    @(negedge clk); ack_slot = 1'b0;
    @(negedge clk); #1 got_stop = stop_force; got_last = last_nack;
    @(negedge clk); #1 got_stop2 = stop_force;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R2 reset sda", sda_ack, 1'b1);
    check("R10 reset last_nack", last_nack, 1'b0);
    check("R10 reset stop_force", stop_force, 1'b0);
    check("R10 reset nack_pending", nack_pending, 1'b0);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      mod_rst = 1'b1;
      rx_mode = VEC[v][12:11];
      rbuf_full = VEC[v][10];
      rsr_full = VEC[v][9];
      stop_req = VEC[v][8];
      cnt_zero = VEC[v][7];
      @(negedge clk); mod_rst = 1'b0;
      do_byte(int'(VEC[v][5:2]), VEC[v][6], 1'b0, -1, 1'b0);
      check($sformatf("R1/R3/R6/R7/R8 vec %0d sda", v), got_sda, VEC[v][1]);
      check($sformatf("R12 vec %0d sda held", v), got_sda2, VEC[v][1]);
      check($sformatf("R7/R8 vec %0d stop_force", v), got_stop, VEC[v][0]);
      if (VEC[v][12:11] != 2'b00) check($sformatf("R11 vec %0d last_nack", v), got_last, VEC[v][1]);
      else check("R2 idle last_nack", got_last, 1'b0);
      check($sformatf("R7 vec %0d stop single", v), got_stop2, 1'b0);
    end

    // R4 / R5: late request
    @(negedge clk); mod_rst = 1'b1; rx_mode = 2'b01; rbuf_full = 1'b0; rsr_full = 1'b0;
    stop_req = 1'b0; cnt_zero = 1'b0;
    @(negedge clk); mod_rst = 1'b0;
    do_byte(8, 1'b0, 1'b1, -1, 1'b0);
    check("R4 late request byte acked", got_sda, 1'b0);
    check("R4 request still pending", nack_pending, 1'b1);
    do_byte(8, 1'b0, 1'b0, -1, 1'b0);
    check("R4 next byte refused", got_sda, 1'b1);
    check("R5 pending cleared", nack_pending, 1'b0);
    do_byte(8, 1'b0, 1'b0, -1, 1'b0);
    check("R5 following byte acked", got_sda, 1'b0);

    // R11: outcome held across idle time
    do_byte(8, 1'b1, 1'b0, -1, 1'b0);
    repeat (6) @(negedge clk);
    #1 check("R11 last_nack held", last_nack, 1'b1);

    // R9 then R8: stop rising mid-byte in counted mode
    @(negedge clk); mod_rst = 1'b1; rx_mode = 2'b11; stop_req = 1'b0; cnt_zero = 1'b0;
    @(negedge clk); mod_rst = 1'b0;
    do_byte(8, 1'b0, 1'b0, 3, 1'b0);
    check("R9 new stop refuses", got_sda, 1'b1);
    check("R9 stop_force", got_stop, 1'b1);
    do_byte(8, 1'b0, 1'b0, -1, 1'b0);
    check("R8 held stop without zero acks", got_sda, 1'b0);
    check("R8 no stop_force", got_stop, 1'b0);
    cnt_zero = 1'b1;
    do_byte(8, 1'b0, 1'b0, -1, 1'b0);
    check("R8 counter zero refuses", got_sda, 1'b1);
    check("R8 stop_force at zero", got_stop, 1'b1);

    // R12: overrun arriving mid-slot
    @(negedge clk); mod_rst = 1'b1; rx_mode = 2'b01; stop_req = 1'b0; cnt_zero = 1'b0;
    rbuf_full = 1'b0; rsr_full = 1'b0;
    @(negedge clk); mod_rst = 1'b0;
    do_byte(8, 1'b0, 1'b0, -1, 1'b1);
    check("R12 slot start ack", got_sda, 1'b0);
    check("R12 mid-slot overrun ignored", got_sda2, 1'b0);

    // R10: module reset during slot and clearing of request
    @(negedge clk); mod_rst = 1'b1; ack_slot = 1'b1;
    #1 check("R10 sda released in reset", sda_ack, 1'b1);
    @(negedge clk); ack_slot = 1'b0; mod_rst = 1'b0; rbuf_full = 1'b0; rsr_full = 1'b0;
    nack_req_set = 1'b1;
    @(negedge clk); nack_req_set = 1'b0;
    #1 check("R10 request armed", nack_pending, 1'b1);
    pulse_mod_rst();
    #1 check("R10 request cleared", nack_pending, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule